// File: doc/BRIEF.md
# Parallel ATA PIO Strobe Timing Generator

This block drives the active-low read and write strobes of a parallel ATA port for PIO and multiword DMA data cycles and for task-file register accesses. A 32-bit timing word holds two independent timing sets: one for data transfers and one for task-file accesses. Each set gives the strobe active time, the strobe recovery time and a lead-in high interval that comes before the first cycle of a transfer. Every field counts clock cycles as its value plus one.

A requester presents a cycle with a task-file flag, a read/write flag and a first-cycle flag. The block accepts the cycle only while it is idle. It then runs the optional lead-in, the low phase and the recovery phase in that order, and it pulses `done` in the last recovery cycle. Requests that come inside a burst without the first-cycle flag skip the lead-in, so consecutive data cycles keep their spacing.

Top module: `pata_pio_strobe`

## Requirements
- R1: While reset is asserted and after it is released with no request, `dior_n` and `diow_n` are 1 and `busy` and `done` are 0.
- R2: A data access (`req_taskfile`=0) holds the selected strobe low for word[8:4]+1 consecutive cycles.
- R3: For a data access, the strobe stays high after its low phase for word[3:0]+1 cycles, counted while `busy` is 1. `done` is 1 only in the last of these cycles. `busy` is 0 in the cycle after `done`.
- R4: A task-file access (`req_taskfile`=1) uses word[17:13]+1 cycles for the low phase and word[12:9]+1 cycles for recovery.
- R5: When `req_first` is 1, the strobe stays high while `busy` is 1 for word[24:22]+1 cycles on a data access, or word[27:25]+1 cycles on a task-file access, before the low phase begins. When `req_first` is 0, the low phase starts in the first cycle after acceptance.
- R6: A read (`req_write`=0) drives only `dior_n` low. A write (`req_write`=1) drives only `diow_n` low. The two strobes are never low at the same time.
- R7: A request is accepted only when `busy` is 0, and `busy` is 1 from the cycle after acceptance. A request held asserted during a cycle does not lengthen it. A request present in the `done` cycle does not start a new one.
- R8: The timing fields, the task-file flag and the direction flag are captured at acceptance. A change of the timing word during a cycle does not alter that cycle.
- R9: Bits 21:18 and 31:28 of the timing word (the fast-burst rate, the clock select and the mode enables) have no effect on strobe timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| timing_word | input | 32 | Packed timing configuration |
| req_valid | input | 1 | Cycle request |
| req_taskfile | input | 1 | 1 = task-file register access, 0 = data access |
| req_write | input | 1 | 1 = write strobe, 0 = read strobe |
| req_first | input | 1 | First cycle of a transfer; inserts the lead-in |
| dior_n | output | 1 | Active-low read strobe |
| diow_n | output | 1 | Active-low write strobe |
| busy | output | 1 | A cycle is in progress |
| done | output | 1 | Last recovery cycle of the current access |

## Verification
The bench builds the block with its default parameters: a 32-bit word, 4-bit recovery fields, 5-bit active fields and 3-bit lead-in fields. With these values, all-ones fields give the longest phases (32 low cycles, 16 recovery cycles and 8 lead-in cycles), and zero fields give the one-cycle minimum. The bench covers both extremes for both timing sets, in each direction, with and without the lead-in. Because these default field positions are the ones the timing word defines, the unused bits 21:18 and 31:28 lie where the bench can toggle them to confirm they have no effect.

// File: rtl/pata_strobe_pkg.sv
package pata_strobe_pkg;
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_LEAD = 2'd1,
      PH_LOW  = 2'd2,
      PH_REC  = 2'd3
   } phase_t;

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction
endpackage

// File: rtl/pata_field_pick.sv
module pata_field_pick #(
   parameter int WORD_W  = 32,
   parameter int REC_LSB = 0,
   parameter int REC_W   = 4,
   parameter int ACT_LSB = 4,
   parameter int ACT_W   = 5,
   parameter int LEAD_LSB = 22,
   parameter int LEAD_W  = 3,
   parameter int CNT_W   = 5
) (
   input  logic [WORD_W-1:0] word,
   output logic [CNT_W-1:0]  rec_cnt,
   output logic [CNT_W-1:0]  act_cnt,
   output logic [CNT_W-1:0]  lead_cnt
);
   if (REC_LSB + REC_W > WORD_W || ACT_LSB + ACT_W > WORD_W || LEAD_LSB + LEAD_W > WORD_W) begin : g_bad_pos
      $error("pata_field_pick: field lies outside the timing word");
   end
   if (REC_W > CNT_W || ACT_W > CNT_W || LEAD_W > CNT_W) begin : g_bad_cnt
      $error("pata_field_pick: counter narrower than a field");
   end

   logic unused_word_bits;
   assign unused_word_bits = ^word;

   always_comb begin
      rec_cnt  = '0;
      act_cnt  = '0;
      lead_cnt = '0;
      rec_cnt[REC_W-1:0]   = word[REC_LSB +: REC_W];
      act_cnt[ACT_W-1:0]   = word[ACT_LSB +: ACT_W];
      lead_cnt[LEAD_W-1:0] = word[LEAD_LSB +: LEAD_W];
   end
endmodule

// File: rtl/pata_phase_seq.sv
module pata_phase_seq
   import pata_strobe_pkg::*;
#(
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             first,
   input  logic             wr,
   input  logic [CNT_W-1:0] rec_cnt,
   input  logic [CNT_W-1:0] act_cnt,
   input  logic [CNT_W-1:0] lead_cnt,
   output logic             dior_n,
   output logic             diow_n,
   output logic             busy,
   output logic             done
);
   if (CNT_W < 1) begin : g_bad_w
      $error("pata_phase_seq: CNT_W must be positive");
   end

   phase_t           ph;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] rec_q;
   logic [CNT_W-1:0] act_q;
   logic             wr_q;
   logic             cnt_zero;

   assign cnt_zero = (cnt == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph    <= PH_IDLE;
         cnt   <= '0;
         rec_q <= '0;
         act_q <= '0;
         wr_q  <= 1'b0;
      end else begin
         unique case (ph)
            PH_IDLE: begin
               if (start) begin
                  rec_q <= rec_cnt;
                  act_q <= act_cnt;
                  wr_q  <= wr;
                  if (first) begin
                     ph  <= PH_LEAD;
                     cnt <= lead_cnt;
                  end else begin
                     ph  <= PH_LOW;
                     cnt <= act_cnt;
                  end
               end
            end
            PH_LEAD: begin
               if (cnt_zero) begin
                  ph  <= PH_LOW;
                  cnt <= act_q;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            PH_LOW: begin
               if (cnt_zero) begin
                  ph  <= PH_REC;
                  cnt <= rec_q;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            PH_REC: begin
               if (cnt_zero) begin
                  ph <= PH_IDLE;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            default: ph <= PH_IDLE;
         endcase
      end
   end

   assign dior_n = !((ph == PH_LOW) && !wr_q);
   assign diow_n = !((ph == PH_LOW) && wr_q);
   assign busy   = (ph != PH_IDLE);
   assign done   = (ph == PH_REC) && cnt_zero;

   // R6: the two strobes never overlap
   assert_one_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(!dior_n && !diow_n));
   // R3: done only during recovery, with both strobes released
   assert_done_strobes_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (dior_n && diow_n && busy));
   // R3: the cycle ends right after done
   assert_done_ends_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy);
   // R7: an idle request is taken on the next edge
   assert_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start) |=> busy);
   // R7: a running phase is never cut short or restarted
   assert_hold_phase_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !cnt_zero) |=> (ph == $past(ph)));
   // R8: captured direction stays fixed while busy
   assert_dir_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(wr_q));
endmodule

// File: rtl/pata_pio_strobe.sv
module pata_pio_strobe
   import pata_strobe_pkg::*;
#(
   parameter int WORD_W       = 32,
   parameter int DAT_REC_LSB  = 0,
   parameter int DAT_REC_W    = 4,
   parameter int DAT_ACT_LSB  = 4,
   parameter int DAT_ACT_W    = 5,
   parameter int CMD_REC_LSB  = 9,
   parameter int CMD_REC_W    = 4,
   parameter int CMD_ACT_LSB  = 13,
   parameter int CMD_ACT_W    = 5,
   parameter int DAT_LEAD_LSB = 22,
   parameter int DAT_LEAD_W   = 3,
   parameter int CMD_LEAD_LSB = 25,
   parameter int CMD_LEAD_W   = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] timing_word,
   input  logic              req_valid,
   input  logic              req_taskfile,
   input  logic              req_write,
   input  logic              req_first,
   output logic              dior_n,
   output logic              diow_n,
   output logic              busy,
   output logic              done
);
   localparam int CNT_W = max3(max3(DAT_REC_W, DAT_ACT_W, DAT_LEAD_W),
                               max3(CMD_REC_W, CMD_ACT_W, CMD_LEAD_W), 1);
   localparam int NSETS = 2;

   if (WORD_W < 1) begin : g_bad_word
      $error("pata_pio_strobe: WORD_W must be positive");
   end

   logic [CNT_W-1:0] rec_set  [NSETS];
   logic [CNT_W-1:0] act_set  [NSETS];
   logic [CNT_W-1:0] lead_set [NSETS];

   for (genvar s = 0; s < NSETS; s++) begin : g_set
      pata_field_pick #(
         .WORD_W  (WORD_W),
         .REC_LSB (s == 0 ? DAT_REC_LSB  : CMD_REC_LSB),
         .REC_W   (s == 0 ? DAT_REC_W    : CMD_REC_W),
         .ACT_LSB (s == 0 ? DAT_ACT_LSB  : CMD_ACT_LSB),
         .ACT_W   (s == 0 ? DAT_ACT_W    : CMD_ACT_W),
         .LEAD_LSB(s == 0 ? DAT_LEAD_LSB : CMD_LEAD_LSB),
         .LEAD_W  (s == 0 ? DAT_LEAD_W   : CMD_LEAD_W),
         .CNT_W   (CNT_W)
      ) u_pick (
         .word    (timing_word),
         .rec_cnt (rec_set[s]),
         .act_cnt (act_set[s]),
         .lead_cnt(lead_set[s])
      );
   end

   logic             start;
   logic [CNT_W-1:0] rec_sel;
   logic [CNT_W-1:0] act_sel;
   logic [CNT_W-1:0] lead_sel;

   assign start    = req_valid && !busy;
   assign rec_sel  = req_taskfile ? rec_set[1]  : rec_set[0];
   assign act_sel  = req_taskfile ? act_set[1]  : act_set[0];
   assign lead_sel = req_taskfile ? lead_set[1] : lead_set[0];

   pata_phase_seq #(.CNT_W(CNT_W)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .first   (req_first),
      .wr      (req_write),
      .rec_cnt (rec_sel),
      .act_cnt (act_sel),
      .lead_cnt(lead_sel),
      .dior_n  (dior_n),
      .diow_n  (diow_n),
      .busy    (busy),
      .done    (done)
   );

   // R1: idle port keeps both strobes released
   assert_idle_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (dior_n && diow_n && !done));
endmodule

// File: tb/sim_pata_pio_strobe.sv
`timescale 1ns/1ps
module sim_pata_pio_strobe;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] timing_word = '0;
   logic        req_valid = 1'b0;
   logic        req_taskfile = 1'b0;
   logic        req_write = 1'b0;
   logic        req_first = 1'b0;
   logic        dior_n, diow_n, busy, done;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   pata_pio_strobe u0 (
      .clk(clk), .rst_n(rst_n), .timing_word(timing_word),
      .req_valid(req_valid), .req_taskfile(req_taskfile),
      .req_write(req_write), .req_first(req_first),
      .dior_n(dior_n), .diow_n(diow_n), .busy(busy), .done(done)
   );

   typedef struct packed {
      logic [31:0] word;
      logic        tf;
      logic        wr;
      logic        first;
   } vec_t;

   localparam int NV = 10;
   localparam vec_t VECS [NV] = '{
      '{32'h0000_0000, 1'b0, 1'b0, 1'b0},
      '{32'h0000_0000, 1'b1, 1'b1, 1'b1},
      '{32'h0FC3_FFFF, 1'b0, 1'b1, 1'b1},
      '{32'h0FC3_FFFF, 1'b1, 1'b0, 1'b1},
      '{32'h0280_0153, 1'b0, 1'b0, 1'b1},
      '{32'h0280_0153, 1'b0, 1'b1, 1'b0},
      '{32'h0A41_8A27, 1'b1, 1'b0, 1'b0},
      '{32'h0A41_8A27, 1'b1, 1'b1, 1'b1},
      '{32'h0540_4E31, 1'b0, 1'b0, 1'b1},
      '{32'h0540_4E31, 1'b1, 1'b1, 1'b0}
   };

   function automatic int exp_lead(logic [31:0] w, logic tf, logic first);
      if (!first) return 0;
      return tf ? int'(w[27:25]) + 1 : int'(w[24:22]) + 1;
   endfunction
   function automatic int exp_low(logic [31:0] w, logic tf);
      return tf ? int'(w[17:13]) + 1 : int'(w[8:4]) + 1;
   endfunction
   function automatic int exp_rec(logic [31:0] w, logic tf);
      return tf ? int'(w[12:9]) + 1 : int'(w[3:0]) + 1;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   // drive one access at a negedge and measure it; word switches to alt after acceptance
   task automatic run_cycle(input logic [31:0] word, input logic [31:0] alt,
                            input logic tf, input logic wr, input logic first,
                            input bit hold_req);
      int lead, low, rec, dn, wrong, st, n;
      bit last_done;
      string lowtag, rectag;
      lead = 0; low = 0; rec = 0; dn = 0; wrong = 0; st = 0; n = 0; last_done = 0;
      timing_word  = word;
      req_taskfile = tf;
      req_write    = wr;
      req_first    = first;
      req_valid    = 1'b1;
      @(negedge clk);
      if (!hold_req) req_valid = 1'b0;
      timing_word = alt;
      while (n < 400) begin
         logic sel;
         if (!busy) break;
         sel = wr ? diow_n : dior_n;
         if (wr ? !dior_n : !diow_n) wrong++;
         if (st == 0) begin
            if (!sel) begin st = 1; low++; end else lead++;
         end else if (st == 1) begin
            if (!sel) low++; else begin st = 2; rec++; end
         end else begin
            rec++;
         end
         if (done) dn++;
         last_done = done;
         @(negedge clk);
         n++;
      end
      req_valid = 1'b0;
      if (n >= 400) check(0, "R7 cycle never ended", n, 0);
      lowtag = tf ? "R4 task-file low" : "R2 data low";
      rectag = tf ? "R4 task-file recovery" : "R3 data recovery";
      check(lead == exp_lead(word, tf, first), "R5 lead-in", lead, exp_lead(word, tf, first));
      check(low == exp_low(word, tf), lowtag, low, exp_low(word, tf));
      check(rec == exp_rec(word, tf), rectag, rec, exp_rec(word, tf));
      check(wrong == 0, "R6 other strobe low", wrong, 0);
      check(dn == 1 && last_done, "R3 single done in last cycle", dn, 1);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      check(dior_n && diow_n && !busy && !done, "R1 during reset", {dior_n, diow_n, busy, done}, 4'b1100);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check(dior_n && diow_n && !busy && !done, "R1 after reset", {dior_n, diow_n, busy, done}, 4'b1100);

      // table walk: R2 R3 R4 R5 R6, back to back
      for (int i = 0; i < NV; i++) begin
         run_cycle(VECS[i].word, VECS[i].word, VECS[i].tf, VECS[i].wr, VECS[i].first, 1'b0);
      end

      // R7: request held through the whole cycle gives exactly one cycle
      run_cycle(32'h0180_0073, 32'h0180_0073, 1'b0, 1'b0, 1'b1, 1'b1);
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         check(!busy && dior_n && diow_n, "R7 no restart after done", busy, 0);
      end

      // R8: changing the word mid-cycle leaves the captured timing alone
      run_cycle(32'h0240_4A52, 32'h0000_0000, 1'b1, 1'b1, 1'b1, 1'b0);
      run_cycle(32'h0000_0000, 32'h0FFF_FFFF, 1'b0, 1'b0, 1'b1, 1'b0);

      // R9: unused bits set: same timing as the plain fields
      run_cycle(32'hF03C_0000 | 32'h0300_2A95, 32'hF03C_0000 | 32'h0300_2A95, 1'b0, 1'b1, 1'b1, 1'b0);
      run_cycle(32'hF03C_0000 | 32'h0300_2A95, 32'hF03C_0000 | 32'h0300_2A95, 1'b1, 1'b0, 1'b1, 1'b0);

      // R1: reset in the middle of a low phase releases the strobes
      timing_word = 32'h0000_01F0; req_write = 1'b0; req_taskfile = 1'b0; req_first = 1'b0;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check(dior_n && diow_n && !busy && !done, "R1 reset mid-cycle", {dior_n, diow_n, busy, done}, 4'b1100);
      rst_n = 1'b1;
      @(negedge clk);
      summary();
   end
endmodule